// File: doc/BRIEF.md
# Round-Robin Workgroup Dispatcher for a 3D Grid

The block hands out the workgroups of a three-dimensional compute grid to a set of `NUM_CU` compute units. A kernel load captures the grid extent and the workgroup extent in x, y and z, clears the workgroup index and the flat global counter, and raises the grid-left flag. Every later scan request walks the compute units one per clock, in round-robin order. The walk starts at a pointer that is kept from one scan to the next. Each compute unit that reports ready while workgroups remain receives a one-cycle start pulse. The pulse carries the unit number, the current 3D workgroup index and the global workgroup number. The index then steps forward, with x carrying into y and y carrying into z.

The control is a three-state machine. In IDLE the block waits. A kernel load (LOAD transition, IDLE to IDLE) takes priority over a scan request (GO transition, IDLE to PROBE). In PROBE one unit is examined per cycle. The block leaves PROBE for FINISH on the cycle it examines its `NUM_CU`-th unit (SWEEP_END transition), or at once when a dispatch uses up the grid (EXHAUST transition). FINISH always returns to IDLE (RETIRE transition) and sends out the scan-done pulse together with the dispatched-anything flag.

Top module: `wg_dispatch`

## Requirements
- R1: After reset, `start_valid`, `scan_done`, `grid_left` and `busy` are all 0.
- R2: `kern_load` in IDLE captures the six extents, zeroes the x/y/z index and the global number, and sets `grid_left` one cycle later. The first start after a load carries index (0,0,0) and global number 0.
- R3: A scan accepted in IDLE examines at most `NUM_CU` units, one per clock. `scan_done` goes high for exactly one cycle, 2 + (number of units examined) cycles after the cycle in which `scan_go` is sampled.
- R4: The unit pointer steps by one modulo `NUM_CU` on every examined unit, whether or not that unit receives work. A new scan starts at the unit after the last one examined, including across kernel loads.
- R5: An examined unit i receives a workgroup only when `grid_left` is 1 and bit i of `cu_ready` is 1.
- R6: Each dispatch raises `start_valid` for one cycle, on the clock after the unit is examined. `start_cu` holds the unit number, `start_id_x/y/z` hold the index and `start_gid` holds the global number. The global number then grows by one and the x index grows by one.
- R7: When (x+1)·wg_x ≥ grid_x, x returns to 0 and y grows by one. When (y+1)·wg_y ≥ grid_y as well, y returns to 0 and z grows by one.
- R8: When that z step gives (z+1)·wg_z ≥ grid_z, `grid_left` falls in the same cycle as the start pulse, and the scan examines no further units.
- R9: During the `scan_done` cycle, `scan_any` is 1 exactly when the scan dispatched at least one workgroup.
- R10: A scan with `grid_left` at 0 still examines all `NUM_CU` units and dispatches nothing, whatever `cu_ready` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kern_load | input | 1 | Load grid and workgroup extents (taken in IDLE) |
| grid_x | input | DIM_W | Grid extent, x |
| grid_y | input | DIM_W | Grid extent, y |
| grid_z | input | DIM_W | Grid extent, z |
| wg_x | input | DIM_W | Workgroup extent, x |
| wg_y | input | DIM_W | Workgroup extent, y |
| wg_z | input | DIM_W | Workgroup extent, z |
| scan_go | input | 1 | Request one scan (taken in IDLE when no load) |
| cu_ready | input | NUM_CU | Bit i: unit i can take a workgroup |
| start_valid | output | 1 | One-cycle start pulse |
| start_cu | output | CU_W | Unit receiving the workgroup |
| start_id_x | output | DIM_W | Workgroup index, x |
| start_id_y | output | DIM_W | Workgroup index, y |
| start_id_z | output | DIM_W | Workgroup index, z |
| start_gid | output | GID_W | Flat global workgroup number |
| scan_done | output | 1 | One-cycle end-of-scan pulse |
| scan_any | output | 1 | At least one dispatch in the finished scan |
| grid_left | output | 1 | Workgroups remain in the grid |
| busy | output | 1 | State machine is out of IDLE |

## Verification
A reference model runs in the bench. It is fed the following scans:
- All units ready: separates a missing dispatch from a missing pointer step.
- A sparse ready mask: shows that idle units still move the pointer.
- An empty mask: shows that a full sweep with no work gives `scan_any` of 0.
- A grid that runs out part-way through a scan: exposes carry mistakes in x to y to z, an early-end fault in the sweep length, and a pointer that fails to persist.
- A reload followed by a single-unit grid: checks that the index is cleared while the pointer is kept, and that x, y and z all carry in one step.
- Scans after exhaustion: check that readiness is ignored once the grid is used up.

// File: rtl/wgd_pkg.sv
package wgd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE  = 2'd1,
        ST_FINISH = 2'd2
    } wgd_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wgd_probe_ptr.sv
module wgd_probe_ptr #(
    parameter int NUM_CU = 4,
    parameter int CU_W   = wgd_pkg::idx_width(NUM_CU)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [CU_W-1:0] ptr,
    output logic            last_probe
);
    localparam int CNT_W = wgd_pkg::idx_width(NUM_CU);
    localparam logic [CU_W-1:0]  PTR_MAX = CU_W'(NUM_CU - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_CU - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last_probe = (cnt_q == CNT_MAX);

    // pointer persists across scans; counter only lives inside one scan
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr   <= '0;
            cnt_q <= '0;
        end else if (step) begin
            ptr   <= (ptr == PTR_MAX) ? '0 : ptr + 1'b1;
            cnt_q <= last_probe ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/wgd_id_gen.sv
module wgd_id_gen #(
    parameter int DIM_W = 8,
    parameter int GID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [DIM_W-1:0] grid_x,
    input  logic [DIM_W-1:0] grid_y,
    input  logic [DIM_W-1:0] grid_z,
    input  logic [DIM_W-1:0] wg_x,
    input  logic [DIM_W-1:0] wg_y,
    input  logic [DIM_W-1:0] wg_z,
    output logic [DIM_W-1:0] id_x,
    output logic [DIM_W-1:0] id_y,
    output logic [DIM_W-1:0] id_z,
    output logic [GID_W-1:0] gid,
    output logic             remain,
    output logic             last_wg
);
    localparam int NDIM   = 3;
    localparam int PROD_W = 2 * DIM_W + 1;

    logic [DIM_W-1:0] grid_q [NDIM];
    logic [DIM_W-1:0] wg_q   [NDIM];
    logic [DIM_W-1:0] idx_q  [NDIM];
    logic [NDIM-1:0]  wrap;

    // wrap[d]: the next index in dimension d would step past the grid edge
    generate
        for (genvar d = 0; d < NDIM; d++) begin : g_dim
            assign wrap[d] = ((PROD_W'(idx_q[d]) + PROD_W'(1)) * PROD_W'(wg_q[d]))
                             >= PROD_W'(grid_q[d]);
        end
    endgenerate

    assign last_wg = &wrap;
    assign id_x    = idx_q[0];
    assign id_y    = idx_q[1];
    assign id_z    = idx_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int d = 0; d < NDIM; d++) begin
                grid_q[d] <= '0;
                wg_q[d]   <= '0;
                idx_q[d]  <= '0;
            end
            gid    <= '0;
            remain <= 1'b0;
        end else if (load) begin
            grid_q[0] <= grid_x;
            grid_q[1] <= grid_y;
            grid_q[2] <= grid_z;
            wg_q[0]   <= wg_x;
            wg_q[1]   <= wg_y;
            wg_q[2]   <= wg_z;
            for (int d = 0; d < NDIM; d++) idx_q[d] <= '0;
            gid    <= '0;
            remain <= 1'b1;
        end else if (advance && remain) begin
            gid <= gid + 1'b1;
            if (!wrap[0]) begin
                idx_q[0] <= idx_q[0] + 1'b1;
            end else begin
                idx_q[0] <= '0;
                if (!wrap[1]) begin
                    idx_q[1] <= idx_q[1] + 1'b1;
                end else begin
                    idx_q[1] <= '0;
                    idx_q[2] <= idx_q[2] + 1'b1;
                    if (wrap[2]) remain <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/wg_dispatch.sv
module wg_dispatch #(
    parameter int NUM_CU = 4,
    parameter int DIM_W  = 8,
    parameter int GID_W  = 16,
    parameter int CU_W   = wgd_pkg::idx_width(NUM_CU)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kern_load,
    input  logic [DIM_W-1:0]  grid_x,
    input  logic [DIM_W-1:0]  grid_y,
    input  logic [DIM_W-1:0]  grid_z,
    input  logic [DIM_W-1:0]  wg_x,
    input  logic [DIM_W-1:0]  wg_y,
    input  logic [DIM_W-1:0]  wg_z,
    input  logic              scan_go,
    input  logic [NUM_CU-1:0] cu_ready,
    output logic              start_valid,
    output logic [CU_W-1:0]   start_cu,
    output logic [DIM_W-1:0]  start_id_x,
    output logic [DIM_W-1:0]  start_id_y,
    output logic [DIM_W-1:0]  start_id_z,
    output logic [GID_W-1:0]  start_gid,
    output logic              scan_done,
    output logic              scan_any,
    output logic              grid_left,
    output logic              busy
);
    import wgd_pkg::*;

    wgd_state_e       state_q, state_d;
    logic [CU_W-1:0]  ptr;
    logic             last_probe;
    logic             hit;
    logic             last_wg;
    logic             load_ok;
    logic             go_ok;
    logic [DIM_W-1:0] cur_x, cur_y, cur_z;
    logic [GID_W-1:0] cur_gid;

    assign load_ok = (state_q == ST_IDLE) && kern_load;
    assign go_ok   = (state_q == ST_IDLE) && !kern_load && scan_go;
    assign hit     = (state_q == ST_PROBE) && grid_left && cu_ready[ptr];
    assign busy    = (state_q != ST_IDLE);

    wgd_probe_ptr #(
        .NUM_CU (NUM_CU),
        .CU_W   (CU_W)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (state_q == ST_PROBE),
        .ptr        (ptr),
        .last_probe (last_probe)
    );

    wgd_id_gen #(
        .DIM_W (DIM_W),
        .GID_W (GID_W)
    ) u_ids (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_ok),
        .advance (hit),
        .grid_x  (grid_x),
        .grid_y  (grid_y),
        .grid_z  (grid_z),
        .wg_x    (wg_x),
        .wg_y    (wg_y),
        .wg_z    (wg_z),
        .id_x    (cur_x),
        .id_y    (cur_y),
        .id_z    (cur_z),
        .gid     (cur_gid),
        .remain  (grid_left),
        .last_wg (last_wg)
    );

    // next-state logic: LOAD, GO, SWEEP_END, EXHAUST, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go_ok) state_d = ST_PROBE;
            ST_PROBE:  if ((hit && last_wg) || last_probe) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_valid <= 1'b0;
            start_cu    <= '0;
            start_id_x  <= '0;
            start_id_y  <= '0;
            start_id_z  <= '0;
            start_gid   <= '0;
            scan_done   <= 1'b0;
            scan_any    <= 1'b0;
        end else begin
            start_valid <= hit;
            scan_done   <= (state_q == ST_FINISH);
            if (hit) begin
                start_cu   <= ptr;
                start_id_x <= cur_x;
                start_id_y <= cur_y;
                start_id_z <= cur_z;
                start_gid  <= cur_gid;
            end
            if (go_ok)    scan_any <= 1'b0;
            else if (hit) scan_any <= 1'b1;
        end
    end

endmodule

// File: rtl/wgd_dispatch_chk.sv
module wgd_dispatch_chk #(
    parameter int NUM_CU = 4,
    parameter int CU_W   = wgd_pkg::idx_width(NUM_CU)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CU-1:0] cu_ready,
    input logic              grid_left,
    input logic              busy,
    input logic              start_valid,
    input logic [CU_W-1:0]   start_cu,
    input logic              scan_done,
    input logic              scan_any
);
    localparam int LEN_W = $clog2(NUM_CU + 4) + 1;

    logic [NUM_CU-1:0] ready_q;
    logic              seen_q;
    logic [LEN_W-1:0]  len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= '0;
            seen_q  <= 1'b0;
            len_q   <= '0;
        end else begin
            ready_q <= cu_ready;
            if (scan_done)        seen_q <= 1'b0;
            else if (start_valid) seen_q <= 1'b1;
            len_q <= busy ? len_q + 1'b1 : '0;
        end
    end

    p_idle_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> busy);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    // R3: a scan is never longer than NUM_CU probes plus the finish cycle
    always_ff @(posedge clk) begin
        if (rst_n) p_scan_len_r3: assert (len_q <= LEN_W'(NUM_CU + 1));
    end

    p_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> ready_q[start_cu]);

    p_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> $past(grid_left));

    p_exhaust_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grid_left) |-> start_valid);

    p_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (scan_any == seen_q));

endmodule

bind wg_dispatch wgd_dispatch_chk #(.NUM_CU(NUM_CU), .CU_W(CU_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cu_ready    (cu_ready),
    .grid_left   (grid_left),
    .busy        (busy),
    .start_valid (start_valid),
    .start_cu    (start_cu),
    .scan_done   (scan_done),
    .scan_any    (scan_any)
);

// File: tb/wg_dispatch_test.sv
module wg_dispatch_test;
    localparam int NCU   = 4;
    localparam int DW    = 8;
    localparam int GW    = 16;
    localparam int CW    = 2;
    localparam int ITEMW = CW + 3 * DW + GW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kern_load = 1'b0;
    logic scan_go = 1'b0;
    logic [DW-1:0] grid_x = '0, grid_y = '0, grid_z = '0;
    logic [DW-1:0] wg_x = '0, wg_y = '0, wg_z = '0;
    logic [NCU-1:0] cu_ready = '0;
    logic start_valid, scan_done, scan_any, grid_left, busy;
    logic [CW-1:0] start_cu;
    logic [DW-1:0] start_id_x, start_id_y, start_id_z;
    logic [GW-1:0] start_gid;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [ITEMW-1:0] exp_q [$];

    // reference model state
    int mx, my, mz, mgid, mptr = 0;
    int gx, gy, gz, wx, wy, wz;
    bit mleft = 1'b0;

    always #10 clk = ~clk;

    wg_dispatch #(.NUM_CU(NCU), .DIM_W(DW), .GID_W(GW)) uut (
        .clk(clk), .rst_n(rst_n), .kern_load(kern_load),
        .grid_x(grid_x), .grid_y(grid_y), .grid_z(grid_z),
        .wg_x(wg_x), .wg_y(wg_y), .wg_z(wg_z),
        .scan_go(scan_go), .cu_ready(cu_ready),
        .start_valid(start_valid), .start_cu(start_cu),
        .start_id_x(start_id_x), .start_id_y(start_id_y), .start_id_z(start_id_z),
        .start_gid(start_gid), .scan_done(scan_done), .scan_any(scan_any),
        .grid_left(grid_left), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop and compare every start pulse
    always @(negedge clk) begin
        if (rst_n && start_valid && !finished) begin
            logic [ITEMW-1:0] act;
            act = {start_cu, start_id_x, start_id_y, start_id_z, start_gid};
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected start", longint'(act), 0);
            end else begin
                logic [ITEMW-1:0] e;
                e = exp_q.pop_front();
                check(act == e, "R6 R7 start contents", longint'(act), longint'(e));
            end
        end
    end

    task automatic load_kernel(input int ax, ay, az, bx, by, bz);
        gx = ax; gy = ay; gz = az; wx = bx; wy = by; wz = bz;
        grid_x = DW'(ax); grid_y = DW'(ay); grid_z = DW'(az);
        wg_x = DW'(bx); wg_y = DW'(by); wg_z = DW'(bz);
        kern_load = 1'b1;
        @(negedge clk);
        kern_load = 1'b0;
        mx = 0; my = 0; mz = 0; mgid = 0; mleft = 1'b1;
        check(grid_left == 1'b1, "R2 grid_left after load", grid_left, 1);
    endtask

    task automatic run_scan(input logic [NCU-1:0] rdy, input string req);
        int probes = 0;
        bit any = 1'b0;
        int cyc;
        for (int c = 0; c < NCU; c++) begin
            int u;
            u = mptr;
            mptr = (mptr + 1) % NCU;
            probes++;
            if (mleft && rdy[u]) begin
                logic [CW-1:0] uc;
                uc = CW'(u);
                any = 1'b1;
                exp_q.push_back({uc, DW'(mx), DW'(my), DW'(mz), GW'(mgid)});
                mgid++;
                mx++;
                if (mx * wx >= gx) begin
                    mx = 0; my++;
                    if (my * wy >= gy) begin
                        my = 0; mz++;
                        if (mz * wz >= gz) mleft = 1'b0;
                    end
                end
                if (!mleft) break;
            end
        end
        cu_ready = rdy;
        scan_go = 1'b1;
        @(negedge clk);
        scan_go = 1'b0;
        cyc = 1;
        while (!scan_done && cyc < 64) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == probes + 2, {req, " R3 R8 scan length"}, cyc, probes + 2);
        check(scan_any == any, {req, " R9 scan_any"}, scan_any, any);
        check(grid_left == mleft, {req, " R8 grid_left"}, grid_left, mleft);
        check(exp_q.size() == 0, {req, " R6 missing starts"}, exp_q.size(), 0);
        @(negedge clk);
        check(scan_done == 1'b0, {req, " R3 done pulse width"}, scan_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(start_valid == 1'b0, "R1 start_valid", start_valid, 0);
        check(scan_done == 1'b0, "R1 scan_done", scan_done, 0);
        check(grid_left == 1'b0, "R1 grid_left", grid_left, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // 3 x 2 x 2 = 12 workgroups
        load_kernel(5, 2, 3, 2, 1, 2);
        run_scan(4'b1111, "all-ready");
        run_scan(4'b0101, "sparse");         // R4: idle units still step the pointer
        run_scan(4'b0000, "none-ready");
        run_scan(4'b1111, "all-ready-2");
        run_scan(4'b1111, "exhaust");        // ends after two probes, pointer at 2
        run_scan(4'b1111, "R10 after-exhaust");
        // R4: pointer survives a reload; order is unit 2 then unit 0
        load_kernel(2, 1, 1, 1, 1, 1);
        run_scan(4'b0101, "R4 reload");
        run_scan(4'b0010, "R10 after-exhaust-2");
        check(start_valid == 1'b0, "R10 no start while idle", start_valid, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL R3 watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule